// File: doc/BRIEF.md
# Tiled Distributed RAM

This block is a small random-access memory assembled only from 16-entry, 1-bit storage cells. Each cell writes on the rising clock edge and reads combinationally. The cells are arranged in one column per data bit. When the configured depth is larger than 16, address bits from bit 4 upward pick the 16-entry cell that receives the write strobe, and the same bits pick which cell's read bit reaches the output. Parameters set the shape. The single-port shapes are 16x8, 32x4, 64x2 and 128x1. The dual-port shapes are 16x4, 32x2 and 64x1.

In dual-port mode every cell has a twin. Both twins take the same write: same strobe, same bit, same address from port A. The first twin reads at the port A address. The second twin reads at the port B address. Port B can therefore only read, and it sees every write as soon as the write commits. An optional output register, clocked by the memory clock, turns both reads into synchronous reads. A synchronous active-high reset clears only that register.

Top module: `dram_tiled`

## Requirements
- R1: Every location holds the parameter INIT_WORD until it is first written, and a read before any write returns that value.
- R2: With we high at a rising edge, din is stored at addr_a. With we low, no location changes.
- R3: With OUT_REG=0, dout_a follows addr_a combinationally. A read of the address being written returns the old word before the edge and the new word after it.
- R4: The address bits from bit 4 upward select one 16-entry cell per bit. A write reaches only that cell, so a location that shares the low four address bits but lies in another cell keeps its value.
- R5: With DUAL_PORT=1, dout_b returns the word stored at addr_b. Writes always use addr_a and never addr_b.
- R6: With DUAL_PORT=1, the two ports read independently in the same cycle. During a write through port A, port B reading the same address sees the old word before the edge and the new word after it.
- R7: With DUAL_PORT=0, dout_b is held at zero.
- R8: With OUT_REG=1, each rising edge loads dout_a and dout_b with the words read just before that edge. A read of the address being written therefore returns the old word (read-before-write).
- R9: With OUT_REG=1, rst high at a rising edge clears the output registers to zero and leaves the stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory and output-register clock |
| rst | input | 1 | Synchronous active-high clear of the output registers |
| we | input | 1 | Active-high write strobe |
| addr_a | input | $clog2(DEPTH) | Port A address for reads and writes |
| din | input | WIDTH | Write data |
| addr_b | input | $clog2(DEPTH) | Port B read address (dual-port only) |
| dout_a | output | WIDTH | Port A read data |
| dout_b | output | WIDTH | Port B read data, zero in single-port mode |

## Verification
A write through port A and a read of the same address, on either port, can fall in the same cycle. The stimulus table sets addr_a and addr_b to the written address while the write strobe is high. It checks the combinational outputs before the edge for the old word and in the following cycle for the new word. In the registered build, the same collision is judged one edge later: the register must capture the old word.

// File: rtl/dram_pkg.sv
package dram_pkg;
  // Geometry of the primitive storage cell the array is tiled from.
  localparam int CELL_DEPTH = 16;
  localparam int CELL_AW    = 4;
endpackage

// File: rtl/dram_cell16.sv
module dram_cell16 #(
  parameter logic [15:0] INIT = '0
) (
  input  logic       clk,
  input  logic       we,
  input  logic [3:0] waddr,
  input  logic       wbit,
  input  logic [3:0] raddr,
  output logic       rbit
);
  logic [15:0] bits = INIT;

  // Edge-triggered write, combinational read.
  always_ff @(posedge clk) begin
    if (we) bits[waddr] <= wbit;
  end

  assign rbit = bits[raddr];
endmodule

// File: rtl/dram_column.sv
module dram_column
  import dram_pkg::*;
#(
  parameter int  DEPTH    = 32,
  parameter bit  DUAL     = 1'b1,
  parameter bit  INIT_BIT = 1'b0,
  localparam int AW   = $clog2(DEPTH),
  localparam int NBLK = DEPTH / CELL_DEPTH,
  localparam int SW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  input  logic          wbit,
  output logic          rbit_a,
  output logic          rbit_b
);
  logic [NBLK-1:0] blk_we;
  logic [NBLK-1:0] rd_a_blk;
  logic [NBLK-1:0] rd_b_blk;
  logic [SW-1:0]   sel_a;
  logic [SW-1:0]   sel_b;

  // Upper address bits pick the 16-entry cell.
  if (NBLK > 1) begin : g_sel
    assign sel_a = addr_a[AW-1:CELL_AW];
    assign sel_b = addr_b[AW-1:CELL_AW];
  end else begin : g_nosel
    assign sel_a = '0;
    assign sel_b = '0;
  end

  always_comb begin
    for (int i = 0; i < NBLK; i++) begin
      blk_we[i] = we && (sel_a == SW'(i));
    end
  end

  for (genvar i = 0; i < NBLK; i++) begin : g_blk
    dram_cell16 #(.INIT({16{INIT_BIT}})) u_cell_a (
      .clk  (clk),
      .we   (blk_we[i]),
      .waddr(addr_a[CELL_AW-1:0]),
      .wbit (wbit),
      .raddr(addr_a[CELL_AW-1:0]),
      .rbit (rd_a_blk[i])
    );
    if (DUAL) begin : g_twin
      // Twin copy: written through port A, read through port B.
      dram_cell16 #(.INIT({16{INIT_BIT}})) u_cell_b (
        .clk  (clk),
        .we   (blk_we[i]),
        .waddr(addr_a[CELL_AW-1:0]),
        .wbit (wbit),
        .raddr(addr_b[CELL_AW-1:0]),
        .rbit (rd_b_blk[i])
      );
    end else begin : g_notwin
      assign rd_b_blk[i] = 1'b0;
    end
  end

  assign rbit_a = rd_a_blk[sel_a];

  if (DUAL) begin : g_rb
    assign rbit_b = rd_b_blk[sel_b];
  end else begin : g_norb
    logic unused_b;
    assign unused_b = ^{addr_b, rd_b_blk, sel_b};
    assign rbit_b   = 1'b0;
  end

  // R4: a write strobe reaches at most one cell, and exactly one when we is high.
  p_one_cell_r4: assert property (@(posedge clk) $onehot0(blk_we));
  p_we_hits_r4:  assert property (@(posedge clk) we |-> ($countones(blk_we) == 1));
endmodule

// File: rtl/dram_tiled.sv
module dram_tiled
  import dram_pkg::*;
#(
  parameter int              DEPTH     = 32,
  parameter int              WIDTH     = 2,
  parameter bit              DUAL_PORT = 1'b1,
  parameter bit              OUT_REG   = 1'b0,
  parameter logic [WIDTH-1:0] INIT_WORD = '0,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr_a,
  input  logic [WIDTH-1:0] din,
  input  logic [AW-1:0]    addr_b,
  output logic [WIDTH-1:0] dout_a,
  output logic [WIDTH-1:0] dout_b
);
  logic [WIDTH-1:0] rd_a;
  logic [WIDTH-1:0] rd_b;

  for (genvar c = 0; c < WIDTH; c++) begin : g_col
    dram_column #(
      .DEPTH   (DEPTH),
      .DUAL    (DUAL_PORT),
      .INIT_BIT(INIT_WORD[c])
    ) u_col (
      .clk   (clk),
      .we    (we),
      .addr_a(addr_a),
      .addr_b(addr_b),
      .wbit  (din[c]),
      .rbit_a(rd_a[c]),
      .rbit_b(rd_b[c])
    );
  end

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk) begin
      if (rst) begin
        dout_a <= '0;
        dout_b <= '0;
      end else begin
        dout_a <= rd_a;
        dout_b <= rd_b;
      end
    end
    // R9: reset clears the read registers.
    p_rst_clears_r9: assert property (@(posedge clk) rst |=> (dout_a == '0 && dout_b == '0));
  end else begin : g_comb
    logic unused_rst;
    assign unused_rst = rst;
    assign dout_a     = rd_a;
    assign dout_b     = rd_b;
  end

  // R3: a committed write is visible next cycle at the same address.
  p_write_visible_r3: assert property (@(posedge clk) disable iff (rst)
    we |=> ((addr_a != $past(addr_a)) || (rd_a == $past(din))));

  if (DUAL_PORT) begin : g_dual_chk
    // R6: twin copies hold identical contents.
    p_twins_agree_r6: assert property (@(posedge clk) disable iff (rst)
      (addr_a == addr_b) |-> (rd_a == rd_b));
  end
endmodule

// File: tb/dram_tiled_tb_top.sv
`timescale 1ns/1ps
module dram_tiled_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // Dual-port 32x2, combinational read, every word starts at 2.
  logic       we = 1'b0;
  logic [4:0] aa = '0;
  logic [4:0] ab = '0;
  logic [1:0] din = '0;
  logic [1:0] qa, qb;

  dram_tiled #(.DEPTH(32), .WIDTH(2), .DUAL_PORT(1'b1), .OUT_REG(1'b0),
               .INIT_WORD(2'b10)) dut_i (
    .clk(clk), .rst(rst), .we(we), .addr_a(aa), .din(din),
    .addr_b(ab), .dout_a(qa), .dout_b(qb));

  // Single-port 128x1, registered read, every bit starts at 1.
  logic       r_we = 1'b0;
  logic [6:0] r_addr = '0;
  logic [6:0] r_ab = '0;
  logic       r_din = 1'b0;
  logic       r_qa, r_qb;

  dram_tiled #(.DEPTH(128), .WIDTH(1), .DUAL_PORT(1'b0), .OUT_REG(1'b1),
               .INIT_WORD(1'b1)) dut_reg_i (
    .clk(clk), .rst(rst), .we(r_we), .addr_a(r_addr), .din(r_din),
    .addr_b(r_ab), .dout_a(r_qa), .dout_b(r_qb));

  typedef struct packed {
    logic       w;
    logic [4:0] a;
    logic [4:0] b;
    logic [1:0] d;
    logic [1:0] ea;
    logic [1:0] eb;
  } vec_t;

  // Expected values are sampled before the row's edge.
  localparam vec_t TBL [11] = '{
    '{1'b0, 5'd0,  5'd17, 2'd0, 2'd2, 2'd2},  // R1 untouched words
    '{1'b1, 5'd3,  5'd3,  2'd1, 2'd2, 2'd2},  // R3 R6 old word before edge
    '{1'b0, 5'd3,  5'd3,  2'd0, 2'd1, 2'd1},  // R3 R6 new word after edge
    '{1'b1, 5'd19, 5'd3,  2'd3, 2'd2, 2'd1},  // R4 other cell, same low bits
    '{1'b0, 5'd3,  5'd19, 2'd0, 2'd1, 2'd3},  // R4 word 3 intact, R5 port B
    '{1'b1, 5'd31, 5'd30, 2'd0, 2'd2, 2'd2},  // R2 top address
    '{1'b0, 5'd31, 5'd31, 2'd0, 2'd0, 2'd0},  // R2 stored
    '{1'b1, 5'd0,  5'd31, 2'd3, 2'd2, 2'd0},  // R5 write uses addr_a
    '{1'b0, 5'd0,  5'd31, 2'd0, 2'd3, 2'd0},  // R5 addr_b word kept
    '{1'b0, 5'd5,  5'd0,  2'd1, 2'd2, 2'd3},  // R2 we low
    '{1'b0, 5'd5,  5'd5,  2'd0, 2'd2, 2'd2}   // R2 nothing written
  };

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_r(input logic w, input logic [6:0] a, input logic d);
    @(negedge clk);
    r_we = w; r_addr = a; r_din = d;
    @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog expired before completion");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    #2;
    check("R9 reset clears dout_a", {1'b0, r_qa}, 2'd0);
    check("R7 single-port dout_b zero", {1'b0, r_qb}, 2'd0);
    rst = 1'b0;

    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      we = TBL[i].w; aa = TBL[i].a; ab = TBL[i].b; din = TBL[i].d;
      #2;
      check($sformatf("R1 R2 R3 R4 R5 R6 row %0d port A", i), qa, TBL[i].ea);
      check($sformatf("R1 R2 R5 R6 row %0d port B", i), qb, TBL[i].eb);
    end
    @(negedge clk);
    we = 1'b0;

    step_r(1'b0, 7'd100, 1'b0);
    check("R1 R8 registered init read", {1'b0, r_qa}, 2'd1);
    step_r(1'b1, 7'd100, 1'b0);
    check("R8 read-before-write", {1'b0, r_qa}, 2'd1);
    step_r(1'b0, 7'd100, 1'b0);
    check("R2 R8 written word", {1'b0, r_qa}, 2'd0);
    step_r(1'b0, 7'd36, 1'b0);
    check("R4 other cell untouched", {1'b0, r_qa}, 2'd1);
    rst = 1'b1;
    step_r(1'b0, 7'd36, 1'b0);
    check("R9 reset clears register", {1'b0, r_qa}, 2'd0);
    rst = 1'b0;
    step_r(1'b0, 7'd36, 1'b0);
    check("R9 contents survive reset", {1'b0, r_qa}, 2'd1);
    check("R7 dout_b stays zero", {1'b0, r_qb}, 2'd0);
    step_r(1'b0, 7'd100, 1'b0);
    check("R9 written word survives reset", {1'b0, r_qa}, 2'd0);

    finish_run();
  end
endmodule